// File: doc/BRIEF.md
# Serial Port Transmitter with Interrupt Request Unit

This block holds the transmit half of a serial port and the request logic that tells a processor when to service it. Software writes a data word into a holding buffer. When the shifter is free the word moves into it and goes out on the line, one bit per baud tick. The frame is either an asynchronous frame with start and stop bits, or a plain synchronous frame that comes with a shift clock. An external receiver reports a loaded frame and the errors it found through single-cycle strobes.

There are four request sources: transmit, receive, error and buffer-empty. Each has an 8-bit control word that holds a request flag, an enable, a 4-bit interrupt level and a 2-bit group level. A source raises its request line when both its flag and its enable are set, and it presents its level fields to an external arbiter. The frame, parity and overrun status flags are sticky and are cleared only by software. The error request flag, by contrast, drops when the arbiter acknowledges it.

Top module: `sci_irq_unit`

## Requirements
- R1: After reset, every control word reads 0, no request line is high, `txd` is 1 and `sclk_out` is 0.
- R2: Control words sit at address 0 (transmit), 1 (receive), 2 (error) and 3 (buffer-empty). Within each word, bit 7 is the request flag, bit 6 the enable, bits 5:2 the interrupt level and bits 1:0 the group level. Bits 15:8 read as 0. A write loads bits 7:0.
- R3: `irq_req[i]` is high exactly when flag and enable of source i are both set (bit 0 transmit, 1 receive, 2 error, 3 buffer-empty). `irq_ilvl[4i+3:4i]` and `irq_glvl[2i+1:2i]` carry the level fields of source i.
- R4: An acknowledge on `irq_ack[i]` clears flag i. A hardware set event in the same cycle as a software write or an acknowledge leaves the flag set.
- R5: A write to address 4 while the shifter is idle moves the word into the shifter on the following clock edge. At that same edge the buffer-empty flag is set and the frame begins.
- R6: A write to address 4 during a frame is held. It moves into the shifter on the clock edge after the edge that ends the frame's last bit, and it sets the buffer-empty flag only then.
- R7: With `sync_mode` low, a frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. The bit changes on each baud tick. The idle line is 1.
- R8: In asynchronous mode the transmit flag is set at the baud tick that begins the stop bit.
- R9: With `sync_mode` high, a frame is 8 data bits LSB first. `sclk_out` is high during the baud-tick cycles of the frame. The transmit flag is set only at the tick that ends the final data bit.
- R10: `rx_loaded` sets the receive flag. If that flag is already set when the strobe arrives, the overrun status flag is set as well.
- R11: The frame and parity error strobes and an overrun each set their status flag and the error flag. The status flags read at address 5: bit 0 frame, bit 1 parity, bit 2 overrun.
- R12: An acknowledge of the error source does not change the status flags. Writing 1 to a status bit at address 5 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| baud_tick | input | 1 | One-cycle bit-time pulse |
| sync_mode | input | 1 | 1 selects synchronous framing |
| rx_loaded | input | 1 | Receiver placed a frame in its buffer |
| rx_frame_err | input | 1 | Receiver saw a frame error |
| rx_parity_err | input | 1 | Receiver saw a parity error |
| irq_ack | input | 4 | Per-source acknowledge |
| irq_req | output | 4 | Per-source request (flag AND enable) |
| irq_ilvl | output | 16 | Interrupt level per source |
| irq_glvl | output | 8 | Group level per source |
| txd | output | 1 | Serial data out |
| sclk_out | output | 1 | Shift clock in synchronous mode |

## Verification
The bench builds the block with the default 8-bit data width. At that width the frame is 10 bits in asynchronous mode and 8 in synchronous mode, so both frames can be walked tick by tick against bit patterns the bench computes itself. This also places the asynchronous request exactly one tick before frame end and the synchronous request at frame end. The short frames make it cheap to hold a second write mid-frame and to observe the one-cycle gap before the held word is loaded.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int NUM_SRC = 4;
    localparam int ILVL_W  = 4;
    localparam int GLVL_W  = 2;
    localparam int ADDR_W  = 3;

    localparam int IDX_TX   = 0;
    localparam int IDX_RX   = 1;
    localparam int IDX_ERR  = 2;
    localparam int IDX_TBUF = 3;

    localparam logic [ADDR_W-1:0] A_TXDATA  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ERRSTAT = 3'd5;

    typedef struct packed {
        logic              req;
        logic              en;
        logic [ILVL_W-1:0] ilvl;
        logic [GLVL_W-1:0] glvl;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
    } err_t;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;

    function automatic logic [15:0] ctrl_word(ctrl_t c);
        return {8'h00, c};
    endfunction

endpackage

// File: rtl/sci_ctrl_reg.sv
module sci_ctrl_reg
    import sci_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    input  logic  hw_set,
    input  logic  ack,
    output ctrl_t ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_en)
                ctrl <= wr_val;
            else if (ack)
                ctrl.req <= 1'b0;
            if (hw_set)
                ctrl.req <= 1'b1;
        end
    end

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> ctrl.req); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !hw_set && !wr_en) |=> !ctrl.req); // R4

endmodule

// File: rtl/sci_tx_engine.sv
module sci_tx_engine
    import sci_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic              sync_mode,
    output logic              txd,
    output logic              sclk_out,
    output logic              load_evt,
    output logic              tx_evt
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_ASYNC = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_SYNC  = CNT_W'(DATA_W - 1);

    tx_state_e          state;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_q;
    logic [FRAME_W-1:0] shreg;
    logic               mode_q;
    logic [CNT_W-1:0]   bit_idx;
    logic [CNT_W-1:0]   last_idx;
    logic               frame_done;

    always_comb begin
        last_idx   = mode_q ? LAST_SYNC : LAST_ASYNC;
        load_evt   = (state == TX_IDLE) && hold_full;
        frame_done = (state == TX_SHIFT) && baud_tick && (bit_idx == last_idx);
        if (mode_q)
            tx_evt = frame_done;
        else
            tx_evt = (state == TX_SHIFT) && baud_tick && (bit_idx == last_idx - 1'b1);
        txd      = (state == TX_SHIFT) ? shreg[0] : 1'b1;
        sclk_out = (state == TX_SHIFT) && mode_q && baud_tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else begin
            if (load_evt)
                hold_full <= 1'b0;
            if (wr_en) begin
                hold_full <= 1'b1;
                hold_q    <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            shreg   <= '1;
            mode_q  <= 1'b0;
            bit_idx <= '0;
        end else if (load_evt) begin
            state   <= TX_SHIFT;
            mode_q  <= sync_mode;
            bit_idx <= '0;
            shreg   <= sync_mode ? {2'b11, hold_q} : {1'b1, hold_q, 1'b0};
        end else if (state == TX_SHIFT && baud_tick) begin
            if (frame_done) begin
                state <= TX_IDLE;
            end else begin
                shreg   <= {1'b1, shreg[FRAME_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> txd); // R7

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (load_evt && !sync_mode) |=> !txd); // R7

    AST_NO_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE) |-> !sclk_out); // R9

    AST_SYNC_REQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        (tx_evt && mode_q) |=> (state == TX_IDLE)); // R9

endmodule

// File: rtl/sci_err_status.sv
module sci_err_status
    import sci_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  err_t set_vec,
    input  logic clr_we,
    input  err_t clr_mask,
    output err_t flags
);

    err_t keep_mask;

    always_comb begin
        keep_mask = clr_we ? err_t'(~clr_mask) : err_t'('1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= err_t'((flags & keep_mask) | set_vec);
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((flags & $past(flags)) == $past(flags))); // R12

endmodule

// File: rtl/sci_irq_unit.sv
module sci_irq_unit
    import sci_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        baud_tick,
    input  logic        sync_mode,
    input  logic        rx_loaded,
    input  logic        rx_frame_err,
    input  logic        rx_parity_err,
    input  logic [3:0]  irq_ack,
    output logic [3:0]  irq_req,
    output logic [15:0] irq_ilvl,
    output logic [7:0]  irq_glvl,
    output logic        txd,
    output logic        sclk_out
);

    ctrl_t              ctrl_q [NUM_SRC];
    logic [NUM_SRC-1:0] hw_set;
    logic               load_evt;
    logic               tx_evt;
    logic               ovr_evt;
    err_t               err_set;
    err_t               err_flags;
    logic               stat_we;
    logic               txd_we;
    logic               unused_hi;

    assign unused_hi = ^bus_wdata[15:8];
    assign stat_we   = bus_we && (bus_addr == A_ERRSTAT);
    assign txd_we    = bus_we && (bus_addr == A_TXDATA);

    always_comb begin
        ovr_evt          = rx_loaded && ctrl_q[IDX_RX].req;
        err_set          = '{ovr: ovr_evt, par: rx_parity_err, frm: rx_frame_err};
        hw_set           = '0;
        hw_set[IDX_TX]   = tx_evt;
        hw_set[IDX_RX]   = rx_loaded;
        hw_set[IDX_ERR]  = rx_frame_err || rx_parity_err || ovr_evt;
        hw_set[IDX_TBUF] = load_evt;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        sci_ctrl_reg u_ctrl (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (bus_we && (bus_addr == ADDR_W'(i))),
            .wr_val (ctrl_t'(bus_wdata[7:0])),
            .hw_set (hw_set[i]),
            .ack    (irq_ack[i]),
            .ctrl   (ctrl_q[i])
        );
        assign irq_req[i]                    = ctrl_q[i].req && ctrl_q[i].en;
        assign irq_ilvl[i*ILVL_W +: ILVL_W]  = ctrl_q[i].ilvl;
        assign irq_glvl[i*GLVL_W +: GLVL_W]  = ctrl_q[i].glvl;
    end

    sci_tx_engine #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (txd_we),
        .wr_data   (bus_wdata[DATA_W-1:0]),
        .baud_tick (baud_tick),
        .sync_mode (sync_mode),
        .txd       (txd),
        .sclk_out  (sclk_out),
        .load_evt  (load_evt),
        .tx_evt    (tx_evt)
    );

    sci_err_status u_err (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (err_set),
        .clr_we   (stat_we),
        .clr_mask (err_t'(bus_wdata[2:0])),
        .flags    (err_flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NUM_SRC))
            bus_rdata = ctrl_word(ctrl_q[bus_addr[1:0]]);
        else if (bus_addr == A_ERRSTAT)
            bus_rdata = {13'h0, err_flags};
    end

    AST_OVR_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
        (rx_loaded && ctrl_q[IDX_RX].req) |=> err_flags.ovr); // R10

    AST_ERR_REQ_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (rx_frame_err || rx_parity_err) |=> ctrl_q[IDX_ERR].req); // R11

    AST_TBUF_REQ_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_evt |=> ctrl_q[IDX_TBUF].req); // R5

endmodule

// File: tb/test_sci_irq_unit.sv
module test_sci_irq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        baud_tick;
    logic        sync_mode;
    logic        rx_loaded;
    logic        rx_frame_err;
    logic        rx_parity_err;
    logic [3:0]  irq_ack;
    logic [3:0]  irq_req;
    logic [15:0] irq_ilvl;
    logic [7:0]  irq_glvl;
    logic        txd;
    logic        sclk_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sci_irq_unit i_sci_irq_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .sync_mode(sync_mode), .rx_loaded(rx_loaded), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_ilvl(irq_ilvl), .irq_glvl(irq_glvl), .txd(txd), .sclk_out(sclk_out)
    );

    typedef struct packed {
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic [3:0]  exp_irq;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{3'd0, 16'hFFFF, 16'h00FF, 4'b0001},
        '{3'd1, 16'h00C5, 16'h00C5, 4'b0011},
        '{3'd2, 16'h0040, 16'h0040, 4'b0011},
        '{3'd3, 16'h0080, 16'h0080, 4'b0011},
        '{3'd0, 16'h0000, 16'h0000, 4'b0010},
        '{3'd3, 16'h00C0, 16'h00C0, 4'b1010},
        '{3'd1, 16'h0040, 16'h0040, 4'b1000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
    endtask

    task automatic pulse_ack(int idx);
        @(negedge clk);
        irq_ack[idx] = 1'b1;
        @(negedge clk);
        irq_ack = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [9:0]  aframe;
        logic [7:0]  sdata;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        baud_tick = 1'b0; sync_mode = 1'b0; rx_loaded = 1'b0;
        rx_frame_err = 1'b0; rx_parity_err = 1'b0; irq_ack = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(3'(a), rd);
            chk("R1 ctrl reset", rd, 16'h0);
        end
        chk("R1 irq_req", irq_req, 4'h0);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 sclk", sclk_out, 1'b0);

        // R2 R3: table of register writes
        for (int k = 0; k < 7; k++) begin
            bus_write(VEC[k].addr, VEC[k].wdata);
            bus_read(VEC[k].addr, rd);
            chk("R2 readback", rd, VEC[k].exp_rd);
            chk("R3 irq_req", irq_req, VEC[k].exp_irq);
        end

        // R3: level fields of the error source
        bus_write(3'd2, 16'h005B);
        chk("R3 ilvl err", irq_ilvl[11:8], 4'h6);
        chk("R3 glvl err", irq_glvl[5:4], 2'h3);
        chk("R3 en without flag", irq_req[2], 1'b0);
        for (int a = 0; a < 4; a++) bus_write(3'(a), 16'h0040);

        // R5 R7 R8: asynchronous frame of 0xA5
        aframe = {1'b1, 8'hA5, 1'b0};
        bus_write(3'd4, 16'h00A5);
        chk("R5 not yet loaded", irq_req[3], 1'b0);
        @(negedge clk);
        chk("R5 tbuf flag on load", irq_req[3], 1'b1);
        chk("R7 start bit", txd, aframe[0]);
        for (int b = 1; b < 10; b++) begin
            if (b == 9) chk("R8 no tx flag before stop", irq_req[0], 1'b0);
            tick();
            chk("R7 frame bit", txd, aframe[b]);
        end
        chk("R8 tx flag at stop bit", irq_req[0], 1'b1);
        tick();
        chk("R7 idle after frame", txd, 1'b1);

        // R6: write held during a frame
        bus_write(3'd0, 16'h0040);
        bus_write(3'd4, 16'h0011);
        @(negedge clk);
        bus_write(3'd3, 16'h0040);
        tick();
        bus_write(3'd4, 16'h0022);
        chk("R6 held write no flag", irq_req[3], 1'b0);
        for (int b = 2; b < 10; b++) tick();
        chk("R6 still shifting first word", txd, 1'b1);
        tick();
        chk("R6 idle between frames", txd, 1'b1);
        chk("R6 flag not yet", irq_req[3], 1'b0);
        @(negedge clk);
        chk("R6 held word loaded", irq_req[3], 1'b1);
        chk("R6 start of second frame", txd, 1'b0);
        tick();
        chk("R6 second word bit0", txd, 1'b0);
        for (int b = 2; b < 11; b++) tick();

        // R9: synchronous frame of 0x3C
        bus_write(3'd0, 16'h0040);
        bus_write(3'd3, 16'h0040);
        sync_mode = 1'b1;
        sdata = 8'h3C;
        bus_write(3'd4, 16'h003C);
        @(negedge clk);
        chk("R9 bit0", txd, sdata[0]);
        chk("R9 sclk low between ticks", sclk_out, 1'b0);
        baud_tick = 1'b1;
        #1;
        chk("R9 sclk high on tick", sclk_out, 1'b1);
        @(negedge clk);
        baud_tick = 1'b0;
        chk("R9 bit1", txd, sdata[1]);
        for (int b = 2; b < 8; b++) begin
            tick();
            chk("R9 data bit", txd, sdata[b]);
        end
        chk("R9 no tx flag during last bit", irq_req[0], 1'b0);
        tick();
        chk("R9 tx flag after last bit", irq_req[0], 1'b1);
        chk("R9 idle after frame", txd, 1'b1);
        sync_mode = 1'b0;

        // R4: acknowledge clears a flag
        bus_write(3'd1, 16'h00C0);
        pulse_ack(1);
        bus_read(3'd1, rd);
        chk("R4 ack clears rx flag", rd, 16'h0040);

        // R4 R10: hardware set beats a software clear in the same cycle
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 16'h0040; bus_we = 1'b1; rx_loaded = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; rx_loaded = 1'b0;
        bus_read(3'd1, rd);
        chk("R4 hw set wins", rd, 16'h00C0);
        bus_read(3'd5, rd);
        chk("R10 no overrun from first load", rd, 16'h0000);

        // R10 R11: second load while pending
        @(negedge clk);
        rx_loaded = 1'b1;
        @(negedge clk);
        rx_loaded = 1'b0;
        bus_read(3'd5, rd);
        chk("R10 overrun status", rd, 16'h0004);
        chk("R11 err request", irq_req[2], 1'b1);

        // R12: error acknowledge keeps status
        pulse_ack(2);
        chk("R12 err flag cleared", irq_req[2], 1'b0);
        bus_read(3'd5, rd);
        chk("R12 status persists", rd, 16'h0004);

        // R11: frame and parity strobes
        @(negedge clk);
        rx_frame_err = 1'b1; rx_parity_err = 1'b1;
        @(negedge clk);
        rx_frame_err = 1'b0; rx_parity_err = 1'b0;
        bus_read(3'd5, rd);
        chk("R11 status all", rd, 16'h0007);
        chk("R11 err request again", irq_req[2], 1'b1);

        // R12: software clear of one status bit
        bus_write(3'd5, 16'h0001);
        bus_read(3'd5, rd);
        chk("R12 write-one clear", rd, 16'h0006);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule